// File: doc/BRIEF.md
# Masked Pending-Interrupt Aggregator

This block gathers up to eight device interrupt sources into one pending register and drives a single level-sensitive request line toward an upstream interrupt controller. Devices set pending bits with a post vector and remove them with a clear vector. A CPU register port writes an enable mask, reads the mask and the pending register back, and acknowledges one source at a time by its number. The request line is high whenever some pending bit is also enabled. It is recomputed on the same clock edge that changes the pending register or the mask.

The mask port works in inverted polarity. The CPU writes 0 to enable a source, and it reads back exactly the byte it wrote. Two further register slots stand in for a cascaded second controller. Its mask is only stored, its status always reads zero, and writes to its acknowledge slot do nothing. Priority, vectoring and edge sampling are outside this block.

The CPU port is a request stream plus a read-response stream, both valid/ready. A request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. A read places its data on the response stream in the next cycle. The response stays valid and stable until `cpu_rsp_ready` is seen high. While a response is waiting unaccepted, new requests are held off.

Top module: `masked_irq_agg`

## Requirements
- R1: After reset the pending register is 0x00, the enable mask is 0x00 (all sources masked), `irq_out` is low, `cpu_rsp_valid` is low and `cpu_req_ready` is high.
- R2: A write to address 0 stores the bitwise complement of the data byte as the enable mask, so a 0 bit enables its source. A read of address 0 returns the complement of the enable mask, which is the byte last written.
- R3: A read of address 1 returns the pending register as it stood when the read was accepted.
- R4: `irq_out` is high exactly when (pending AND enable) is nonzero. It takes its new value on the same edge that updates the pending register or the mask. A mask write can therefore raise or drop it directly.
- R5: On each edge, `dev_post` is ORed into the pending register, and pending bits set in `dev_clear` are removed.
- R6: A write to address 1 is an acknowledge. Only data bits [3:0] are used, as a source index. An index 0 to 7 clears that one pending bit, and an index 8 to 15 changes nothing.
- R7: If a bit is posted in the same cycle that it is cleared or acknowledged, the post wins and the bit ends set.
- R8: Address 2 holds the secondary mask, read back as written. Address 3 always reads 0x00, and writes to it are ignored. Addresses 4 to 7 read 0x00, and writes to them are ignored.
- R9: `cpu_req_ready` equals (not `cpu_rsp_valid`) or `cpu_rsp_ready`. An accepted read raises `cpu_rsp_valid` on the next cycle. While `cpu_rsp_valid` is high and `cpu_rsp_ready` is low, the response data holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_post | input | 8 | Per-source set request, sampled every edge |
| dev_clear | input | 8 | Per-source clear request, sampled every edge |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | CPU request can be accepted |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 3 | Register slot |
| cpu_req_wdata | input | 8 | Write data |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_ready | input | 1 | Consumer takes the read data |
| cpu_rsp_data | output | 8 | Read data |
| irq_out | output | 1 | Level interrupt request upstream |

## Verification
Every state change here lands on the edge that accepts its cause. A post, clear, acknowledge or mask write shows in `irq_out` one edge after it is driven. A read's data appears one edge after acceptance. The bench drives stimulus at a falling edge and samples at the next falling edge, so each check sees the value due one rising edge later. Back-pressure checks hold `cpu_rsp_ready` low for several cycles. They confirm the response and its data do not move and the next request waits.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MASK_PRI = 3'd0,
    ADR_STAT_PRI = 3'd1,
    ADR_MASK_SEC = 3'd2,
    ADR_STAT_SEC = 3'd3
  } ipa_addr_e;

  typedef struct packed {
    logic we_mask_pri;
    logic we_ack;
    logic we_mask_sec;
  } ipa_wr_t;
endpackage

// File: rtl/ipa_cpu_port.sv
module ipa_cpu_port
  import ipa_pkg::*;
#(
  parameter int SRC_W = 8,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [SRC_W-1:0]  rsp_data,
  input  logic [SRC_W-1:0]  en_q,
  input  logic [SRC_W-1:0]  sec_q,
  input  logic [SRC_W-1:0]  pend_q,
  output ipa_wr_t           wr,
  output logic [SRC_W-1:0]  wdata,
  output logic [IDX_W-1:0]  ack_idx
);
  logic             accept;
  logic             rd_acc;
  logic [SRC_W-1:0] rd_mux;
  logic             rsp_valid_q;
  logic [SRC_W-1:0] rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_acc    = accept && !req_write;
  assign wdata     = req_wdata;
  assign ack_idx   = req_wdata[IDX_W-1:0];

  always_comb begin
    wr = '0;
    if (accept && req_write) begin
      unique case (req_addr)
        ADR_MASK_PRI: wr.we_mask_pri = 1'b1;
        ADR_STAT_PRI: wr.we_ack      = 1'b1;
        ADR_MASK_SEC: wr.we_mask_sec = 1'b1;
        default:      wr = '0;
      endcase
    end
  end

  always_comb begin
    unique case (req_addr)
      ADR_MASK_PRI: rd_mux = ~en_q;
      ADR_STAT_PRI: rd_mux = pend_q;
      ADR_MASK_SEC: rd_mux = sec_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      if (rd_acc) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // R9: a stalled response does not move
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: an accepted read yields a response next cycle
  p_rd_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R8: the secondary status slot always reads zero
  p_sec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == ADR_STAT_SEC)
      |=> (rsp_data == '0));
endmodule

// File: rtl/ipa_mask.sv
module ipa_mask #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_pri,
  input  logic             we_sec,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] en_q,
  output logic [SRC_W-1:0] en_nxt,
  output logic [SRC_W-1:0] sec_q
);
  assign en_nxt = we_pri ? ~wdata : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      sec_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (we_sec) sec_q <= wdata;
    end
  end

  // R2: the stored enable mask is the complement of the written byte
  p_mask_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_pri |=> (en_q == ~$past(wdata)));
endmodule

// File: rtl/ipa_pending.sv
module ipa_pending #(
  parameter int SRC_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] post,
  input  logic [SRC_W-1:0] clr,
  input  logic             ack_we,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [SRC_W-1:0] pend_q,
  output logic [SRC_W-1:0] pend_nxt
);
  logic [SRC_W-1:0] ack_vec;

  for (genvar i = 0; i < SRC_W; i++) begin : g_ack
    assign ack_vec[i] = ack_we && (ack_idx == IDX_W'(i));
  end

  assign pend_nxt = (pend_q & ~clr & ~ack_vec) | post;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  // R5 / R7: every posted bit is set after the edge
  p_post_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|post) |=> ((pend_q & $past(post)) == $past(post)));

  // R5: cleared bits that are not posted are gone after the edge
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~post)) |=> ((pend_q & $past(clr & ~post)) == '0));

  // R6: an acknowledge index beyond the sources changes nothing
  p_ack_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_idx >= IDX_W'(SRC_W) && clr == '0)
      |=> (pend_q == ($past(pend_q) | $past(post))));
endmodule

// File: rtl/ipa_irq_out.sv
module ipa_irq_out #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] pend_nxt,
  input  logic [SRC_W-1:0] en_nxt,
  input  logic [SRC_W-1:0] pend_q,
  input  logic [SRC_W-1:0] en_q,
  output logic             irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_nxt & en_nxt);
  end

  assign irq = irq_q;

  // R4: the line follows the registered pending and enable state
  p_irq_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(pend_q & en_q)));
endmodule

// File: rtl/masked_irq_agg.sv
module masked_irq_agg
  import ipa_pkg::*;
#(
  parameter int SRC_W = 8,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  dev_post,
  input  logic [SRC_W-1:0]  dev_clear,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [SRC_W-1:0]  cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [SRC_W-1:0]  cpu_rsp_data,
  output logic              irq_out
);
  ipa_wr_t          wr;
  logic [SRC_W-1:0] wdata;
  logic [IDX_W-1:0] ack_idx;
  logic [SRC_W-1:0] en_q, en_nxt, sec_q, pend_q, pend_nxt;

  ipa_cpu_port #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready),
    .req_write(cpu_req_write), .req_addr(cpu_req_addr),
    .req_wdata(cpu_req_wdata),
    .rsp_valid(cpu_rsp_valid), .rsp_ready(cpu_rsp_ready),
    .rsp_data(cpu_rsp_data),
    .en_q(en_q), .sec_q(sec_q), .pend_q(pend_q),
    .wr(wr), .wdata(wdata), .ack_idx(ack_idx)
  );

  ipa_mask #(.SRC_W(SRC_W)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .we_pri(wr.we_mask_pri), .we_sec(wr.we_mask_sec), .wdata(wdata),
    .en_q(en_q), .en_nxt(en_nxt), .sec_q(sec_q)
  );

  ipa_pending #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .post(dev_post), .clr(dev_clear),
    .ack_we(wr.we_ack), .ack_idx(ack_idx),
    .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  ipa_irq_out #(.SRC_W(SRC_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .pend_nxt(pend_nxt), .en_nxt(en_nxt),
    .pend_q(pend_q), .en_q(en_q),
    .irq(irq_out)
  );
endmodule

// File: tb/masked_irq_agg_tb_top.sv
module masked_irq_agg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_post = '0, dev_clear = '0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, irq_out;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  masked_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n),
    .dev_post(dev_post), .dev_clear(dev_clear),
    .cpu_req_valid(req_valid), .cpu_req_ready(req_ready),
    .cpu_req_write(req_write), .cpu_req_addr(req_addr),
    .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(rsp_valid), .cpu_rsp_ready(rsp_ready),
    .cpu_rsp_data(rsp_data), .irq_out(irq_out)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic cpu_read(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 8'hxx;
  endtask

  task automatic dev_pulse(logic [7:0] p, logic [7:0] c);
    @(negedge clk);
    dev_post = p; dev_clear = c;
    @(negedge clk);
    dev_post = '0; dev_clear = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check("R1 req_ready", {7'd0, req_ready}, 8'h01);
    cpu_read(3'd1, d); check("R1 pending", d, 8'h00);
    cpu_read(3'd0, d); check("R1 mask read", d, 8'hFF);
  endtask

  task automatic t_mask_irq();
    logic [7:0] d;
    cpu_write(3'd0, 8'hF0);
    cpu_read(3'd0, d); check("R2 readback", d, 8'hF0);
    dev_pulse(8'h30, 8'h00);
    check("R4 masked post irq", {7'd0, irq_out}, 8'h00);
    cpu_read(3'd1, d); check("R3 status", d, 8'h30);
    cpu_write(3'd0, 8'hEF);
    check("R4 unmask raises", {7'd0, irq_out}, 8'h01);
    cpu_write(3'd0, 8'hFF);
    check("R4 mask drops", {7'd0, irq_out}, 8'h00);
    cpu_write(3'd0, 8'h00);
    check("R4 enable all", {7'd0, irq_out}, 8'h01);
  endtask

  task automatic t_clear_ack();
    logic [7:0] d;
    dev_pulse(8'h00, 8'h10);
    cpu_read(3'd1, d); check("R5 clear", d, 8'h20);
    check("R4 still high", {7'd0, irq_out}, 8'h01);
    cpu_write(3'd1, 8'h15);
    check("R6 ack drops irq", {7'd0, irq_out}, 8'h00);
    cpu_read(3'd1, d); check("R6 ack idx5", d, 8'h00);
    dev_pulse(8'h81, 8'h00);
    check("R5 post irq", {7'd0, irq_out}, 8'h01);
    cpu_write(3'd1, 8'h0C);
    cpu_read(3'd1, d); check("R6 idx12 noop", d, 8'h81);
    cpu_write(3'd1, 8'h00);
    cpu_read(3'd1, d); check("R6 ack idx0", d, 8'h80);
  endtask

  task automatic t_post_wins();
    logic [7:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd1; req_wdata = 8'h07;
    dev_post = 8'h80;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; dev_post = '0;
    cpu_read(3'd1, d); check("R7 post beats ack", d, 8'h80);
    dev_pulse(8'h80, 8'h80);
    cpu_read(3'd1, d); check("R7 post beats clear", d, 8'h80);
  endtask

  task automatic t_secondary();
    logic [7:0] d;
    cpu_write(3'd2, 8'h5A);
    cpu_read(3'd2, d); check("R8 sec mask", d, 8'h5A);
    cpu_write(3'd3, 8'hFF);
    cpu_read(3'd3, d); check("R8 sec status", d, 8'h00);
    cpu_read(3'd1, d); check("R8 sec ack ignored", d, 8'h80);
    cpu_write(3'd5, 8'h33);
    cpu_read(3'd5, d); check("R8 unused reads 0", d, 8'h00);
    cpu_read(3'd0, d); check("R8 unused write ignored", d, 8'h00);
    cpu_read(3'd2, d); check("R8 sec mask kept", d, 8'h5A);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd2;
    @(negedge clk);
    req_addr = 3'd1;
    check("R9 rsp valid", {7'd0, rsp_valid}, 8'h01);
    check("R9 ready low", {7'd0, req_ready}, 8'h00);
    @(negedge clk);
    @(negedge clk);
    check("R9 data held", rsp_data, 8'h5A);
    check("R9 still valid", {7'd0, rsp_valid}, 8'h01);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next read", rsp_data, 8'h80);
    @(negedge clk);
    check("R9 drained", {7'd0, rsp_valid}, 8'h00);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_irq();
    t_clear_ack();
    t_post_wins();
    t_secondary();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule